// File: doc/BRIEF.md
# Pipelined SPI Register Slave

This block lets an SPI host read and modify a small bank of 16-bit registers. The host sends 16-bit command words in SPI mode 3 (clock idles high, data sampled on rising SCLK), most significant bit first. Bit 15 of a word is a direction flag: 0 asks for a read and 1 asks for a write. Bits 14..8 hold a seven-bit register address. For a write, bits 7..0 carry the new low byte of the addressed register.

A read is answered one frame later. The value is captured from the register bank when the read frame ends, and it is shifted out on MISO during the next frame. Because that next frame can itself carry a new read request, a host can stream reads back to back in full duplex. MISO is enabled only in a frame that follows a completed read. At all other times, and whenever chip select is high, it is released.

The SPI pins are oversampled on a system clock that runs at least eight times faster than SCLK. On the system side, a sample strobe loads a whole 16-bit value into one register. This is how fresh sensor data reaches the bank.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, every register reads as 0x0000 and `spi_miso_oe` is low.
- R2: A frame with bit 15 = 0 is a read of address bits 14..8. During the next frame, `spi_miso` presents that register's value MSB first, one bit per SCLK cycle, and `spi_miso_oe` stays high for the whole frame.
- R3: In the first frame after reset, and in any frame that follows a write frame, `spi_miso_oe` stays low.
- R4: While chip select is high, `spi_miso_oe` is low.
- R5: A frame with bit 15 = 1 replaces bits 7..0 of the addressed register with frame bits 7..0 and leaves bits 15..8 unchanged.
- R6: Read requests can be issued in consecutive frames. Each frame returns the register named in the frame before it. This holds whether chip select rises between frames or stays low across them.
- R7: A frame cut short by chip select rising before its 16th rising SCLK edge has no effect. No register changes, and the next full frame returns the response that was pending before the cut frame.
- R8: Addresses at or above NUM_REGS are out of range. A read of such an address returns 0x0000 with MISO still enabled. A write to such an address changes no register, including registers whose index equals its low address bits.
- R9: A one-cycle `sample_stb` writes the whole of `sample_data` into register `sample_addr`.
- R10: SCLK edges while chip select is high are ignored. They do not shift bits into the next frame.
- R11: The read response is fixed when the read frame completes. A register update between that frame and the next does not change the returned value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Command data from the host |
| spi_miso | output | 1 | Response data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |
| sample_stb | input | 1 | One-cycle strobe that loads a full register |
| sample_addr | input | IDX_W | Register index for `sample_stb` |
| sample_data | input | 16 | Value written by `sample_stb` |

## Verification
The bench uses the default of eight registers. With that size, most of the seven-bit address space is out of range, and the out-of-range addresses tested share their low three bits with register 7. A design that drops the range check and only decodes the index bits would therefore corrupt or return register 7, and the bench would catch it. The bench uses SCLK at one tenth of the system clock. This keeps the synchronizer delay visible while preserving the required eight-to-one margin.

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  input  logic             sample_stb,
  input  logic [IDX_W-1:0] sample_addr,
  input  logic [15:0]      sample_data
);
  localparam int FRAME_W = 16;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 7;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [1:0] sclk_sh, cs_sh, din_sh;
  logic       sclk_d, cs_d;
  logic       sclk_s, cs_s, din_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sh <= '1;
      cs_sh   <= '1;
      din_sh  <= '0;
      sclk_d  <= 1'b1;
      cs_d    <= 1'b1;
    end else begin
      sclk_sh <= {sclk_sh[0], spi_sclk};
      cs_sh   <= {cs_sh[0], spi_cs_n};
      din_sh  <= {din_sh[0], spi_mosi};
      sclk_d  <= sclk_s;
      cs_d    <= cs_s;
    end
  end

  assign sclk_s = sclk_sh[1];
  assign cs_s   = cs_sh[1];
  assign din_s  = din_sh[1];

  logic sclk_rise, sclk_fall, cs_fall;
  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
  assign cs_fall   = ~cs_s & cs_d;

  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] rx_sh, rx_next;
  logic               frame_done;

  assign rx_next    = {rx_sh[FRAME_W-2:0], din_s};
  assign frame_done = sclk_rise && (bit_cnt == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (cs_s) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      bit_cnt <= bit_cnt + 1'b1;
      rx_sh   <= rx_next;
    end
  end

  logic              cmd_rd, in_range, spi_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [IDX_W-1:0]  cmd_idx;
  logic [REG_W-1:0]  rd_val;
  logic [NUM_REGS-1:0][REG_W-1:0] regs;

  assign cmd_rd   = ~rx_next[FRAME_W-1];
  assign cmd_addr = rx_next[FRAME_W-2 -: ADDR_W];
  assign cmd_idx  = cmd_addr[IDX_W-1:0];
  assign in_range = int'(cmd_addr) < NUM_REGS;
  assign rd_val   = in_range ? regs[cmd_idx] : '0;
  assign spi_wr   = frame_done & ~cmd_rd & in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (sample_stb && sample_addr == IDX_W'(i)) regs[i] <= sample_data;
        if (spi_wr && cmd_idx == IDX_W'(i)) regs[i][BYTE_W-1:0] <= rx_next[BYTE_W-1:0];
      end
    end
  end

  logic [REG_W-1:0] resp, tx_sh;
  logic             resp_vld, drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp     <= '0;
      resp_vld <= 1'b0;
      tx_sh    <= '0;
      drive    <= 1'b0;
    end else if (frame_done) begin
      resp     <= rd_val;
      resp_vld <= cmd_rd;
      tx_sh    <= rd_val;
      drive    <= cmd_rd;
    end else if (cs_fall) begin
      tx_sh <= resp;
      drive <= resp_vld;
    end else if (sclk_fall && bit_cnt != '0) begin
      tx_sh <= {tx_sh[REG_W-2:0], 1'b0};
    end
  end

  assign spi_miso    = tx_sh[REG_W-1];
  assign spi_miso_oe = drive & ~cs_s;

  AST_HIZ_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(spi_cs_n, 2) && $past(spi_cs_n)) |-> !spi_miso_oe); // R4

  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sclk_fall && !frame_done && !cs_fall) |=> $stable(spi_miso)); // R2

  AST_REGS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!frame_done && !sample_stb) |=> $stable(regs)); // R7

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (bit_cnt == '0)); // R10

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hi_chk
    AST_HIGH_BYTE_GUARD: assert property (@(posedge clk) disable iff (rst)
      !sample_stb |=> $stable(regs[g][REG_W-1:BYTE_W])); // R5
  end
endmodule

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  localparam int NR = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic sample_stb = 1'b0;
  logic [IW-1:0] sample_addr = '0;
  logic [15:0] sample_data = '0;

  int total = 0, bad = 0;

  spi_reg_slave #(.NUM_REGS(NR)) dut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .sample_stb(sample_stb), .sample_addr(sample_addr), .sample_data(sample_data)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input bit hold, output logic [15:0] r,
                      output bit all_oe, output bit any_oe);
    if (spi_cs_n) begin spi_cs_n = 1'b0; #80; end
    all_oe = 1'b1; any_oe = 1'b0; r = '0;
    for (int i = 15; i >= 0; i--) begin
      spi_sclk = 1'b0; spi_mosi = w[i]; #40;
      r[i] = spi_miso; all_oe &= spi_miso_oe; any_oe |= spi_miso_oe;
      spi_sclk = 1'b1; #40;
    end
    #40;
    if (!hold) begin spi_cs_n = 1'b1; #80; end
  endtask

  task automatic partial(input logic [15:0] w, input int nbits);
    spi_cs_n = 1'b0; #80;
    for (int i = 15; i > 15 - nbits; i--) begin
      spi_sclk = 1'b0; spi_mosi = w[i]; #40;
      spi_sclk = 1'b1; #40;
    end
    #40; spi_cs_n = 1'b1; #80;
  endtask

  task automatic load(input logic [IW-1:0] a, input logic [15:0] d);
    @(negedge clk); sample_stb = 1'b1; sample_addr = a; sample_data = d;
    @(negedge clk); sample_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_reg(input logic [6:0] a, output logic [15:0] v);
    logic [15:0] r; bit ao, an;
    xfer({1'b0, a, 8'h00}, 1'b0, r, ao, an);
    xfer(16'h0000, 1'b0, v, ao, an);
  endtask

  task automatic t_reset;
    logic [15:0] r; bit ao, an;
    chk("R1 oe after reset", {15'd0, spi_miso_oe}, 16'd0);
    xfer(16'h0300, 1'b0, r, ao, an);
    chk("R3 no drive in first frame", {15'd0, an}, 16'd0);
    xfer(16'h0000, 1'b0, r, ao, an);
    chk("R1 reset register value", r, 16'h0000);
    chk("R4 oe low with cs high", {15'd0, spi_miso_oe}, 16'd0);
  endtask

  task automatic t_read;
    logic [15:0] r; bit ao, an;
    load(3'd2, 16'hA5C3);
    xfer(16'h0200, 1'b0, r, ao, an);
    xfer(16'h0000, 1'b0, r, ao, an);
    chk("R9 sample load", r, 16'hA5C3);
    chk("R2 oe through response frame", {15'd0, ao}, 16'd1);
  endtask

  task automatic t_write;
    logic [15:0] r; bit ao, an;
    load(3'd5, 16'h1234);
    xfer(16'h85EE, 1'b0, r, ao, an);
    xfer(16'h0500, 1'b0, r, ao, an);
    chk("R3 no drive after write", {15'd0, an}, 16'd0);
    xfer(16'h0000, 1'b0, r, ao, an);
    chk("R5 low byte written", r, 16'h12EE);
  endtask

  task automatic t_stream(input bit hold);
    logic [15:0] r; bit ao, an;
    load(3'd6, 16'hFC18); load(3'd4, 16'h4B4B); load(3'd2, 16'h0D0E);
    xfer(16'h0600, hold, r, ao, an);
    xfer(16'h0400, hold, r, ao, an);
    chk("R6 stream word 1", r, 16'hFC18);
    xfer(16'h0200, hold, r, ao, an);
    chk("R6 stream word 2", r, 16'h4B4B);
    xfer(16'h0000, 1'b0, r, ao, an);
    chk("R6 stream word 3", r, 16'h0D0E);
    chk("R6 oe in last frame", {15'd0, ao}, 16'd1);
  endtask

  task automatic t_abort;
    logic [15:0] r; bit ao, an;
    xfer(16'h0600, 1'b0, r, ao, an);
    partial(16'h86AA, 12);
    xfer(16'h0000, 1'b0, r, ao, an);
    chk("R7 pending response kept", r, 16'hFC18);
    read_reg(7'd6, r);
    chk("R7 aborted write discarded", r, 16'hFC18);
  endtask

  task automatic t_range;
    logic [15:0] r; bit ao, an;
    load(3'd7, 16'hBEEF);
    xfer(16'h8F77, 1'b0, r, ao, an);
    xfer(16'hFF11, 1'b0, r, ao, an);
    xfer(16'h7F00, 1'b0, r, ao, an);
    xfer(16'h0000, 1'b0, r, ao, an);
    chk("R8 out of range read", r, 16'h0000);
    chk("R8 oe on out of range read", {15'd0, ao}, 16'd1);
    read_reg(7'd7, r);
    chk("R8 no aliasing write", r, 16'hBEEF);
  endtask

  task automatic t_idle_sclk;
    logic [15:0] r;
    for (int i = 0; i < 5; i++) begin spi_sclk = 1'b0; #40; spi_sclk = 1'b1; #40; end
    read_reg(7'd2, r);
    chk("R10 idle sclk ignored", r, 16'h0D0E);
  endtask

  task automatic t_latch;
    logic [15:0] r; bit ao, an;
    xfer(16'h0400, 1'b0, r, ao, an);
    load(3'd4, 16'h9999);
    xfer(16'h0400, 1'b0, r, ao, an);
    chk("R11 response latched", r, 16'h4B4B);
    xfer(16'h0000, 1'b0, r, ao, an);
    chk("R11 new value next read", r, 16'h9999);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=0x0000 expected=0x0001");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_stream(1'b0);
    t_stream(1'b1);
    t_abort();
    t_range();
    t_idle_sclk();
    t_latch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule